// File: doc/BRIEF.md
# Pending Miss Tracking File

This block sits beside a non-blocking cache and keeps a small table of the misses that are still waiting for memory. When the cache reports an access that missed, the block either opens a fresh slot for it and issues a memory request, or finds the block already waiting in a slot and reports the access as merged, so no second request goes out for the same block. Each slot remembers the block address, the cache line the block will land in, the word that missed and the register or unit waiting for the data.

When memory returns a block, the slot holding that address is released. On the next cycle the block presents the line, word and destination for one cycle so that the data can be routed. A full flag tells the cache that no slot is free, and a new miss arriving then is refused. Allocation and release in the same cycle both happen, and the freed slot can be taken on the following cycle. All responses to a miss come back in the same cycle, so the cache can present a new miss every cycle.

Top module: `miss_pending_file`

## Requirements
- R1: After reset no slot is occupied: `full` is 0, `done_valid` is 0 and `rsp_kind` is 0.
- R2: A miss to a block that no occupied slot holds, with at least one free slot, gives `rsp_kind` = 1 (allocated), `rsp_slot` = lowest-numbered free slot, and in the same cycle `mem_req_valid` = 1 with `mem_req_blk` = the block and `mem_req_slot` = that slot.
- R3: A new miss is accepted on every cycle with no gap until every slot is occupied.
- R4: A miss to a block held by an occupied slot gives `rsp_kind` = 2 (merged) with `rsp_slot` = that slot, raises no memory request and occupies no new slot.
- R5: `full` is 1 exactly when every slot is occupied; a miss to a block not held gives `rsp_kind` = 3 (refused), no memory request and no change of state, while a miss to a held block is still merged.
- R6: A fill whose address matches an occupied slot frees that slot, and on the next cycle `done_valid` is 1 for exactly one cycle with that slot's line, word and destination.
- R7: A fill whose address matches no occupied slot changes nothing and raises no `done_valid`.
- R8: A miss allocation and a fill release in the same cycle both take effect; `full` is computed from the state before that cycle, and the freed slot is the lowest free slot on the next cycle.
- R9: A miss presented in the same cycle as a fill for the same block is not merged into the retiring slot; it is treated as a new miss.
- R10: With `req_valid` low, `rsp_kind` is 0 and `mem_req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A cache access missed this cycle |
| req_blk | input | BLK_W | Block address of the miss |
| req_line | input | LINE_W | Cache line the block maps to |
| req_word | input | WORD_W | Word within the block that missed |
| req_dest | input | DEST_W | Register or unit waiting for the data |
| rsp_kind | output | 2 | 0 none, 1 allocated, 2 merged, 3 refused |
| rsp_slot | output | IDX_W | Slot allocated or merged into |
| mem_req_valid | output | 1 | Issue a memory read for a new block |
| mem_req_blk | output | BLK_W | Block address to read |
| mem_req_slot | output | IDX_W | Slot that owns the read |
| fill_valid | input | 1 | Memory returns a block this cycle |
| fill_blk | input | BLK_W | Address of the returned block |
| done_valid | output | 1 | Routing information valid (one cycle) |
| done_line | output | LINE_W | Line to write the returned block into |
| done_word | output | WORD_W | Word that missed |
| done_dest | output | DEST_W | Destination waiting for the word |
| full | output | 1 | Every slot is occupied |

## Verification
The miss path is driven with a run of distinct blocks until the table fills, which separates correct lowest-free-slot choice and stall-free acceptance from an encoder that picks the wrong slot or stalls. Repeats of pending blocks, both with free slots and with the table full, tell a true associative hit from a miss that wrongly allocates or is refused. Fills to unknown blocks, fills alongside allocations, and a fill and miss to the same block in one cycle separate correct release and reuse ordering from designs that merge into a retiring slot or fail to free it. Routing outputs are checked through a queue of expected line, word and destination triples, so a missing, duplicated or stretched completion pulse is caught.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

   typedef enum logic [1:0] {
      RSP_NONE   = 2'd0,
      RSP_ALLOC  = 2'd1,
      RSP_MERGE  = 2'd2,
      RSP_REFUSE = 2'd3
   } rsp_kind_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pmf_entry.sv
module pmf_entry #(
   parameter int BLK_W  = 26,
   parameter int LINE_W = 7,
   parameter int WORD_W = 3,
   parameter int DEST_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic [BLK_W-1:0]  wr_blk_i,
   input  logic [LINE_W-1:0] wr_line_i,
   input  logic [WORD_W-1:0] wr_word_i,
   input  logic [DEST_W-1:0] wr_dest_i,
   input  logic [BLK_W-1:0]  look_blk_i,
   input  logic [BLK_W-1:0]  fill_blk_i,
   output logic              valid_o,
   output logic [LINE_W-1:0] line_o,
   output logic [WORD_W-1:0] word_o,
   output logic [DEST_W-1:0] dest_o,
   output logic              look_hit_o,
   output logic              fill_hit_o
);

   logic              valid_q;
   logic [BLK_W-1:0]  blk_q;
   logic [LINE_W-1:0] line_q;
   logic [WORD_W-1:0] word_q;
   logic [DEST_W-1:0] dest_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (set_i) begin
         valid_q <= 1'b1;
      end else if (clr_i) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_q  <= '0;
         line_q <= '0;
         word_q <= '0;
         dest_q <= '0;
      end else if (set_i) begin
         blk_q  <= wr_blk_i;
         line_q <= wr_line_i;
         word_q <= wr_word_i;
         dest_q <= wr_dest_i;
      end
   end

   assign valid_o    = valid_q;
   assign line_o     = line_q;
   assign word_o     = word_q;
   assign dest_o     = dest_q;
   assign look_hit_o = valid_q && (blk_q == look_blk_i);
   assign fill_hit_o = valid_q && (blk_q == fill_blk_i);

   // R2: a slot is only written while it is free
   assert_set_free_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i |-> !valid_q);

   // R6: only an occupied slot is released
   assert_clr_valid_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |-> valid_q);

   // R2: a written slot holds the block on the next cycle
   assert_set_lands_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (valid_q && blk_q == $past(wr_blk_i)));

endmodule

// File: rtl/pmf_pick_free.sv
module pmf_pick_free #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     free_i,
   output logic [N-1:0]     onehot_o,
   output logic [IDX_W-1:0] idx_o
);

   assign onehot_o = free_i & (~free_i + N'(1));

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (free_i[i]) idx_o = IDX_W'(i);
      end
   end

   // R2: the chosen slot is a single free slot
   assert_pick_onehot_R2 : assert final ($onehot0(onehot_o) && ((onehot_o & ~free_i) == '0));

endmodule

// File: rtl/pmf_route.sv
module pmf_route #(
   parameter int N      = 4,
   parameter int LINE_W = 7,
   parameter int WORD_W = 3,
   parameter int DEST_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  logic [N-1:0]      sel_i,
   input  logic [LINE_W-1:0] line_i [N],
   input  logic [WORD_W-1:0] word_i [N],
   input  logic [DEST_W-1:0] dest_i [N],
   output logic              done_valid_o,
   output logic [LINE_W-1:0] done_line_o,
   output logic [WORD_W-1:0] done_word_o,
   output logic [DEST_W-1:0] done_dest_o
);

   logic [LINE_W-1:0] line_m;
   logic [WORD_W-1:0] word_m;
   logic [DEST_W-1:0] dest_m;

   always_comb begin
      line_m = '0;
      word_m = '0;
      dest_m = '0;
      for (int i = 0; i < N; i++) begin
         if (sel_i[i]) begin
            line_m = line_m | line_i[i];
            word_m = word_m | word_i[i];
            dest_m = dest_m | dest_i[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_valid_o <= 1'b0;
         done_line_o  <= '0;
         done_word_o  <= '0;
         done_dest_o  <= '0;
      end else begin
         done_valid_o <= fire_i;
         if (fire_i) begin
            done_line_o <= line_m;
            done_word_o <= word_m;
            done_dest_o <= dest_m;
         end
      end
   end

   // R6: the routing pulse lasts one cycle per release
   assert_done_single_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid_o && !$past(fire_i, 2)) |=> (done_valid_o == $past(fire_i)));

endmodule

// File: rtl/miss_pending_file.sv
module miss_pending_file
   import pmf_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int BLK_W       = 26,
   parameter int LINE_W      = 7,
   parameter int WORD_W      = 3,
   parameter int DEST_W      = 6,
   localparam int IDX_W      = idx_width(NUM_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BLK_W-1:0]  req_blk,
   input  logic [LINE_W-1:0] req_line,
   input  logic [WORD_W-1:0] req_word,
   input  logic [DEST_W-1:0] req_dest,
   output logic [1:0]        rsp_kind,
   output logic [IDX_W-1:0]  rsp_slot,
   output logic              mem_req_valid,
   output logic [BLK_W-1:0]  mem_req_blk,
   output logic [IDX_W-1:0]  mem_req_slot,
   input  logic              fill_valid,
   input  logic [BLK_W-1:0]  fill_blk,
   output logic              done_valid,
   output logic [LINE_W-1:0] done_line,
   output logic [WORD_W-1:0] done_word,
   output logic [DEST_W-1:0] done_dest,
   output logic              full
);

   generate
      if (NUM_ENTRIES < 2 || NUM_ENTRIES > 64) begin : g_bad_depth
         $error("miss_pending_file: NUM_ENTRIES must lie in 2..64");
      end
      if (BLK_W < 1 || LINE_W < 1 || WORD_W < 1 || DEST_W < 1) begin : g_bad_width
         $error("miss_pending_file: every field width must be at least 1");
      end
   endgenerate

   logic [NUM_ENTRIES-1:0] valid_vec;
   logic [NUM_ENTRIES-1:0] look_hit;
   logic [NUM_ENTRIES-1:0] fill_hit;
   logic [NUM_ENTRIES-1:0] look_eff;
   logic [NUM_ENTRIES-1:0] set_vec;
   logic [NUM_ENTRIES-1:0] clr_vec;
   logic [NUM_ENTRIES-1:0] pick_onehot;
   logic [IDX_W-1:0]       pick_idx;
   logic [IDX_W-1:0]       merge_idx;
   logic [LINE_W-1:0]      e_line [NUM_ENTRIES];
   logic [WORD_W-1:0]      e_word [NUM_ENTRIES];
   logic [DEST_W-1:0]      e_dest [NUM_ENTRIES];
   logic                   merge, alloc, refuse, release_any;
   rsp_kind_e              kind;

   generate
      for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
         pmf_entry #(
            .BLK_W (BLK_W),
            .LINE_W(LINE_W),
            .WORD_W(WORD_W),
            .DEST_W(DEST_W)
         ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_vec[g]),
            .clr_i     (clr_vec[g]),
            .wr_blk_i  (req_blk),
            .wr_line_i (req_line),
            .wr_word_i (req_word),
            .wr_dest_i (req_dest),
            .look_blk_i(req_blk),
            .fill_blk_i(fill_blk),
            .valid_o   (valid_vec[g]),
            .line_o    (e_line[g]),
            .word_o    (e_word[g]),
            .dest_o    (e_dest[g]),
            .look_hit_o(look_hit[g]),
            .fill_hit_o(fill_hit[g])
         );
      end
   endgenerate

   pmf_pick_free #(
      .N    (NUM_ENTRIES),
      .IDX_W(IDX_W)
   ) u_pick (
      .free_i  (~valid_vec),
      .onehot_o(pick_onehot),
      .idx_o   (pick_idx)
   );

   // a slot retiring this cycle cannot absorb a new miss
   assign clr_vec     = fill_valid ? fill_hit : '0;
   assign release_any = |clr_vec;
   assign look_eff    = look_hit & ~clr_vec;

   always_comb begin
      merge_idx = '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
         if (look_eff[i]) merge_idx = IDX_W'(i);
      end
   end

   assign full   = &valid_vec;
   assign merge  = req_valid && (|look_eff);
   assign alloc  = req_valid && !merge && !full;
   assign refuse = req_valid && !merge && full;

   assign set_vec = alloc ? pick_onehot : '0;

   always_comb begin
      if (merge)       kind = RSP_MERGE;
      else if (alloc)  kind = RSP_ALLOC;
      else if (refuse) kind = RSP_REFUSE;
      else             kind = RSP_NONE;
   end

   assign rsp_kind      = kind;
   assign rsp_slot      = merge ? merge_idx : (alloc ? pick_idx : '0);
   assign mem_req_valid = alloc;
   assign mem_req_blk   = req_blk;
   assign mem_req_slot  = pick_idx;

   pmf_route #(
      .N     (NUM_ENTRIES),
      .LINE_W(LINE_W),
      .WORD_W(WORD_W),
      .DEST_W(DEST_W)
   ) u_route (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire_i      (release_any),
      .sel_i       (clr_vec),
      .line_i      (e_line),
      .word_i      (e_word),
      .dest_i      (e_dest),
      .done_valid_o(done_valid),
      .done_line_o (done_line),
      .done_word_o (done_word),
      .done_dest_o (done_dest)
   );

   // R4: a block is never held by two slots
   assert_one_holder_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_hit));

   // R4: a merge names an occupied slot and leaves occupancy unchanged when nothing retires
   assert_merge_no_grow_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_kind == 2'd2 && !fill_valid) |=> $stable(valid_vec));

   // R5: a refused miss leaves the table as it was
   assert_refuse_stable_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_kind == 2'd3 && !fill_valid) |=> $stable(valid_vec));

   // R2: an issued memory read owns an occupied slot on the next cycle
   assert_alloc_owns_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> valid_vec[$past(mem_req_slot)]);

   // R6: a matching fill frees one slot and routes on the next cycle
   assert_fill_release_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && (|fill_hit) && !req_valid) |=>
         (done_valid && ($countones(valid_vec) + 1 == $past($countones(valid_vec)))));

   // R7: an unmatched fill produces no routing pulse
   assert_stray_fill_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !(|fill_hit)) |=> !done_valid);

   // R10: no response without a miss
   assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (rsp_kind == 2'd0 && !mem_req_valid));

endmodule

// File: tb/tb_miss_pending_file.sv
`timescale 1ns/1ps
module tb_miss_pending_file;

   localparam int N      = 4;
   localparam int BLK_W  = 26;
   localparam int LINE_W = 7;
   localparam int WORD_W = 3;
   localparam int DEST_W = 6;
   localparam int IDX_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [BLK_W-1:0]  req_blk = '0;
   logic [LINE_W-1:0] req_line = '0;
   logic [WORD_W-1:0] req_word = '0;
   logic [DEST_W-1:0] req_dest = '0;
   logic [1:0]        rsp_kind;
   logic [IDX_W-1:0]  rsp_slot;
   logic              mem_req_valid;
   logic [BLK_W-1:0]  mem_req_blk;
   logic [IDX_W-1:0]  mem_req_slot;
   logic              fill_valid = 1'b0;
   logic [BLK_W-1:0]  fill_blk = '0;
   logic              done_valid;
   logic [LINE_W-1:0] done_line;
   logic [WORD_W-1:0] done_word;
   logic [DEST_W-1:0] done_dest;
   logic              full;

   always #2.5 clk = ~clk;

   miss_pending_file #(
      .NUM_ENTRIES(N), .BLK_W(BLK_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .DEST_W(DEST_W)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_blk(req_blk), .req_line(req_line),
      .req_word(req_word), .req_dest(req_dest),
      .rsp_kind(rsp_kind), .rsp_slot(rsp_slot),
      .mem_req_valid(mem_req_valid), .mem_req_blk(mem_req_blk), .mem_req_slot(mem_req_slot),
      .fill_valid(fill_valid), .fill_blk(fill_blk),
      .done_valid(done_valid), .done_line(done_line), .done_word(done_word),
      .done_dest(done_dest), .full(full)
   );

   int checks = 0;
   int failures = 0;

   typedef struct packed {
      logic [LINE_W-1:0] line;
      logic [WORD_W-1:0] word;
      logic [DEST_W-1:0] dest;
   } route_t;

   route_t expq[$];

   bit                m_valid [N];
   logic [BLK_W-1:0]  m_blk   [N];
   logic [LINE_W-1:0] m_line  [N];
   logic [WORD_W-1:0] m_word  [N];
   logic [DEST_W-1:0] m_dest  [N];

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one cycle of stimulus; responses are predicted from the bench's own table
   task automatic step(input string tag, input bit rv, input logic [BLK_W-1:0] rb,
                       input logic [LINE_W-1:0] rl, input logic [WORD_W-1:0] rw,
                       input logic [DEST_W-1:0] rd, input bit fv,
                       input logic [BLK_W-1:0] fb);
      int fi, hi, lo, cnt, ek, es;
      @(negedge clk);
      req_valid = rv; req_blk = rb; req_line = rl; req_word = rw; req_dest = rd;
      fill_valid = fv; fill_blk = fb;
      #1;
      fi = -1; hi = -1; lo = -1; cnt = 0;
      for (int i = 0; i < N; i++) begin
         if (m_valid[i]) cnt++;
         if (fv && m_valid[i] && m_blk[i] == fb) fi = i;
      end
      for (int i = 0; i < N; i++) begin
         if (rv && m_valid[i] && m_blk[i] == rb && i != fi) hi = i;
      end
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) lo = i;
      es = 0;
      if (!rv)           ek = 0;
      else if (hi >= 0)  begin ek = 2; es = hi; end
      else if (cnt == N) ek = 3;
      else               begin ek = 1; es = lo; end
      chk(tag, "full", 32'(full), 32'(cnt == N));
      chk(tag, "rsp_kind", 32'(rsp_kind), 32'(ek));
      if (ek == 1 || ek == 2) chk(tag, "rsp_slot", 32'(rsp_slot), 32'(es));
      chk(tag, "mem_req_valid", 32'(mem_req_valid), 32'(ek == 1));
      if (ek == 1) begin
         chk(tag, "mem_req_blk", 32'(mem_req_blk), 32'(rb));
         chk(tag, "mem_req_slot", 32'(mem_req_slot), 32'(lo));
      end
      if (fi >= 0) begin
         expq.push_back('{line: m_line[fi], word: m_word[fi], dest: m_dest[fi]});
         m_valid[fi] = 0;
      end
      if (ek == 1) begin
         m_valid[lo] = 1; m_blk[lo] = rb; m_line[lo] = rl; m_word[lo] = rw; m_dest[lo] = rd;
      end
   endtask

   task automatic idle(input string tag);
      step(tag, 0, '0, '0, '0, '0, 0, '0);
   endtask

   task automatic miss(input string tag, input logic [BLK_W-1:0] b, input logic [LINE_W-1:0] l,
                       input logic [WORD_W-1:0] w, input logic [DEST_W-1:0] d);
      step(tag, 1, b, l, w, d, 0, '0);
   endtask

   task automatic fill(input string tag, input logic [BLK_W-1:0] b);
      step(tag, 0, '0, '0, '0, '0, 1, b);
   endtask

   // scoreboard monitor for routing outputs (R6)
   always @(negedge clk) begin
      if (rst_n && done_valid) begin
         if (expq.size() == 0) begin
            checks++; failures++;
            $display("FAIL R6 unexpected done pulse actual=1 expected=0");
         end else begin
            route_t e;
            e = expq.pop_front();
            chk("R6", "done_line", 32'(done_line), 32'(e.line));
            chk("R6", "done_word", 32'(done_word), 32'(e.word));
            chk("R6", "done_dest", 32'(done_dest), 32'(e.dest));
         end
      end
   end

   localparam logic [BLK_W-1:0] BA = 26'h100, BB = 26'h200, BC = 26'h300,
                                BD = 26'h3ffffff, BE = 26'h055, BF = 26'h777,
                                BG = 26'h0a0, BH = 26'h1234;

   task automatic run();
      for (int i = 0; i < N; i++) m_valid[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "full after reset", 32'(full), 0);
      chk("R1", "done_valid after reset", 32'(done_valid), 0);
      chk("R1", "rsp_kind after reset", 32'(rsp_kind), 0);
      idle("R10");
      // R2 / R3: back-to-back misses fill the table lowest slot first
      miss("R2", BA, 7'd5, 3'd2, 6'd11);
      miss("R3", BB, 7'd9, 3'd7, 6'd3);
      miss("R3", BC, 7'd1, 3'd0, 6'd63);
      // R4: repeat of a pending block merges
      miss("R4", BB, 7'd9, 3'd1, 6'd20);
      miss("R3", BD, 7'd127, 3'd5, 6'd1);
      // R5: table full, new block refused, pending block merged
      miss("R5", BE, 7'd2, 3'd3, 6'd4);
      miss("R5", BA, 7'd5, 3'd4, 6'd30);
      idle("R10");
      // R7: fill to an unknown block
      fill("R7", BF);
      idle("R7");
      chk("R7", "no done after stray fill", 32'(done_valid), 0);
      // R8: release and refused miss share a cycle (full taken from prior state)
      step("R8", 1, BE, 7'd2, 3'd3, 6'd4, 1, BB);
      miss("R8", BE, 7'd2, 3'd3, 6'd4);
      // R6: plain release
      fill("R6", BA);
      // R8: allocation and release in the same cycle
      step("R8", 1, BG, 7'd66, 3'd6, 6'd40, 1, BD);
      miss("R8", BH, 7'd33, 3'd1, 6'd9);
      fill("R6", BE);
      // R9: miss and fill to the same block in one cycle
      step("R9", 1, BC, 7'd12, 3'd2, 6'd50, 1, BC);
      miss("R9", BC, 7'd12, 3'd3, 6'd51);
      fill("R9", BC);
      fill("R6", BG);
      fill("R6", BH);
      idle("R6");
      idle("R1");
      chk("R6", "table drained", 32'(full), 0);
      miss("R2", BF, 7'd3, 3'd3, 6'd3);
      fill("R6", BF);
      repeat (3) idle("R10");
      chk("R6", "pending routes left", 32'(expq.size()), 0);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (20000) @(posedge clk);
            failures++;
            $display("FAIL watchdog run did not complete");
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule